// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits between a CPU's physical address and the memory arrays of a small system. For each address it names one target: main RAM, with a 32 KB page index, the 96 KB system BIOS ROM, the 32 KB boot ROM, or the 8 KB disk-option ROM. For the ROM targets it also gives the byte offset into that ROM. If no target matches, it reports an unmapped code, and the data path then returns 0xFF for that read. The decode is purely combinational.

Three pieces of state steer the decode. The first is a window register that moves four 32 KB RAM pages into the 0x80000–0x9FFFF window. The second is a flag that overlays the boot ROM at the top of the first megabyte. The third is a flag that replaces the option-ROM and BIOS areas with shadow RAM. Software sets this state through a byte-wide I/O port interface. The port interface is sampled on the clock edge, and the window register can be read back.

The whole first megabyte is mirrored at the top of the 4 GB space, and the mirror uses the same window and overlay decode. RAM from 1 MB up to 16 MB maps straight through.

Top module: `memmap_decoder`

## Requirements
- R1: Addresses 0x00000–0x7FFFF give target RAM (code 0) with page = address bits 19:15. Addresses 0x100000–0xFFFFFF give RAM with page = address bits 23:15.
- R2: Addresses 0x80000–0x9FFFF give RAM with page = {window[7:1], address[16:15]} (9 bits).
- R3: After reset the window register holds 0x08. While io_addr equals the window port (0x461), io_rdata shows the register. For any other io_addr, io_rdata is 0xFF.
- R4: A write to port 0x461 loads the whole byte only when data bits 7:1 differ from the stored bits 7:1. Otherwise the register, bit 0 included, is unchanged.
- R5: A write of 0x00 or 0x10 to port 0x43D selects the boot ROM. A write of 0x02 or 0x12 deselects it. Any other value has no effect. Reset selects it.
- R6: With the boot ROM selected, 0xF8000–0xFFFFF gives target BOOT (code 2) with offset = address[14:0], and 0xE8000–0xF7FFF is unmapped.
- R7: With the boot ROM deselected, 0xE8000–0xFFFFF gives RAM (page = address[19:15]) when shadow is on. When shadow is off it gives BIOS (code 1) with offset = address − 0xE8000.
- R8: Bit 1 of a write to port 0x53D sets the shadow flag, and reset clears it. With shadow on, 0xC0000–0xDFFFF is RAM. With shadow off, only 0xD8000–0xD9FFF is mapped, as DISK (code 3) with offset = address − 0xD8000.
- R9: Addresses 0xFFF00000–0xFFFFFFFF decode exactly as address[19:0] does.
- R10: The ranges 0xA0000–0xBFFFF and 0xE0000–0xE7FFF are unmapped (code 4). So is every address from 16 MB up to just below 0xFFF00000. The page output is zero unless the target is RAM, and the offset output is zero unless the target is a ROM.
- R11: A port write sampled on a clock edge changes the decode only after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, sampled on the rising edge |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Window register while io_addr is the window port, else 0xFF |
| mem_addr | input | 32 | CPU physical address |
| tgt | output | 3 | Target code: 0 RAM, 1 BIOS, 2 BOOT, 3 DISK, 4 unmapped |
| ram_page | output | 9 | 32 KB RAM page index |
| rom_off | output | 17 | Byte offset inside the selected ROM |

## Verification
The following are checked every cycle:
- the straight low-RAM mapping;
- readback of the window register;
- zeroed page and offset outputs on unmapped accesses;
- the BIOS target appearing only when both flags allow it;
- the next-cycle effect of port writes, including a same-high-bits write to the window port that must leave the register untouched.

Other behaviour is shown only by the bench's reference decode over random addresses and register states:
- the window page arithmetic;
- the mirror at the top of 4 GB;
- the exact ROM offsets;
- how the two overlay flags interact, in every order they can be set.

// File: rtl/mmd_pkg.sv
// Shared types for the banked memory map decoder.
// Assumes a 32-bit physical address and a 16 MB RAM span.
package mmd_pkg;
    typedef enum logic [2:0] {
        TGT_RAM  = 3'd0,
        TGT_BIOS = 3'd1,
        TGT_BOOT = 3'd2,
        TGT_DISK = 3'd3,
        TGT_NONE = 3'd4
    } tgt_e;

    localparam logic [19:0] WIN_LO   = 20'h80000;
    localparam logic [19:0] HOLE_LO  = 20'hA0000;
    localparam logic [19:0] OPT_LO   = 20'hC0000;
    localparam logic [19:0] DISK_LO  = 20'hD8000;
    localparam logic [19:0] DISK_END = 20'hDA000;
    localparam logic [19:0] OPT_END  = 20'hE0000;
    localparam logic [19:0] BIOS_LO  = 20'hE8000;
    localparam logic [19:0] BOOT_LO  = 20'hF8000;
endpackage

// File: rtl/mmd_ctrl_regs.sv
// Control state for the decoder: the window bank register, the boot-ROM
// select flag and the shadow-RAM flag. The port interface is sampled on
// the rising edge, so a write is seen by the decode one cycle later.
// Assumes single-byte port accesses with no wait states.
module mmd_ctrl_regs #(
    parameter int          IO_AW       = 16,
    parameter logic [15:0] WIN_PORT    = 16'h0461,
    parameter logic [15:0] BOOT_PORT   = 16'h043D,
    parameter logic [15:0] SHADOW_PORT = 16'h053D,
    parameter logic [7:0]  WIN_RESET   = 8'h08
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_wr,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       win_q,
    output logic             boot_sel_q,
    output logic             shadow_q
);
    logic hit_win, hit_boot, hit_shadow;
    logic boot_on_code, boot_off_code;

    // Port hit and value decode for the three writable ports.
    always_comb begin
        hit_win       = io_wr && (io_addr == IO_AW'(WIN_PORT));
        hit_boot      = io_wr && (io_addr == IO_AW'(BOOT_PORT));
        hit_shadow    = io_wr && (io_addr == IO_AW'(SHADOW_PORT));
        boot_on_code  = (io_wdata == 8'h00) || (io_wdata == 8'h10);
        boot_off_code = (io_wdata == 8'h02) || (io_wdata == 8'h12);
    end

    // Window register: loads only when the upper seven bits change.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_q <= WIN_RESET;
        else if (hit_win && (io_wdata[7:1] != win_q[7:1]))
            win_q <= io_wdata;
    end

    // Boot-ROM overlay flag: two recognised codes each way.
    always_ff @(posedge clk) begin
        if (!rst_n)
            boot_sel_q <= 1'b1;
        else if (hit_boot && boot_on_code)
            boot_sel_q <= 1'b1;
        else if (hit_boot && boot_off_code)
            boot_sel_q <= 1'b0;
    end

    // Shadow-RAM flag follows bit 1 of each write to its port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= 1'b0;
        else if (hit_shadow)
            shadow_q <= io_wdata[1];
    end
endmodule

// File: rtl/mmd_region_decode.sv
// Combinational address decode. It folds the top-of-4GB mirror onto the
// first megabyte, then applies the window and the ROM/RAM overlays.
// Assumes the control state is stable for the whole cycle.
module mmd_region_decode
    import mmd_pkg::*;
#(
    parameter int PAGE_W = 9,
    parameter int OFF_W  = 17
) (
    input  logic [31:0]       addr,
    input  logic [7:0]        win,
    input  logic              boot_sel,
    input  logic              shadow,
    output tgt_e              tgt,
    output logic [PAGE_W-1:0] page,
    output logic [OFF_W-1:0]  off
);
    localparam int HI_PAGE_MSB = PAGE_W + 14;

    logic [19:0] la;
    logic        low_meg;
    logic        below_top;

    // Region flags: the first megabyte (or its mirror) and RAM up to 16 MB.
    always_comb begin
        la        = addr[19:0];
        low_meg   = (addr[31:20] == 12'h000) || (addr[31:20] == 12'hFFF);
        below_top = (addr[31:HI_PAGE_MSB+1] == '0);
    end

    // Target, page and offset selection.
    always_comb begin
        tgt  = TGT_NONE;
        page = '0;
        off  = '0;
        if (low_meg) begin
            if (la < WIN_LO) begin
                tgt  = TGT_RAM;
                page = PAGE_W'(la[19:15]);
            end else if (la < HOLE_LO) begin
                tgt  = TGT_RAM;
                page = PAGE_W'({win[7:1], la[16:15]});
            end else if (la >= OPT_LO && la < OPT_END) begin
                if (shadow) begin
                    tgt  = TGT_RAM;
                    page = PAGE_W'(la[19:15]);
                end else if (la >= DISK_LO && la < DISK_END) begin
                    tgt = TGT_DISK;
                    off = OFF_W'(la - DISK_LO);
                end
            end else if (la >= BIOS_LO) begin
                if (boot_sel) begin
                    if (la >= BOOT_LO) begin
                        tgt = TGT_BOOT;
                        off = OFF_W'(la[14:0]);
                    end
                end else if (shadow) begin
                    tgt  = TGT_RAM;
                    page = PAGE_W'(la[19:15]);
                end else begin
                    tgt = TGT_BIOS;
                    off = OFF_W'(la - BIOS_LO);
                end
            end
        end else if (below_top) begin
            tgt  = TGT_RAM;
            page = addr[HI_PAGE_MSB:15];
        end
    end
endmodule

// File: rtl/memmap_decoder.sv
// Top of the banked memory map decoder: control registers plus the
// combinational region decode, and readback of the window register.
// Assumes the RAM/ROM arrays and the 0xFF fill of unmapped reads are outside.
module memmap_decoder
    import mmd_pkg::*;
#(
    parameter int          IO_AW       = 16,
    parameter int          PAGE_W      = 9,
    parameter int          OFF_W       = 17,
    parameter logic [15:0] WIN_PORT    = 16'h0461,
    parameter logic [15:0] BOOT_PORT   = 16'h043D,
    parameter logic [15:0] SHADOW_PORT = 16'h053D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic [31:0]       mem_addr,
    output logic [2:0]        tgt,
    output logic [PAGE_W-1:0] ram_page,
    output logic [OFF_W-1:0]  rom_off
);
    logic [7:0] win_q;
    logic       boot_sel_q;
    logic       shadow_q;
    tgt_e       tgt_dec;

    mmd_ctrl_regs #(
        .IO_AW(IO_AW), .WIN_PORT(WIN_PORT), .BOOT_PORT(BOOT_PORT),
        .SHADOW_PORT(SHADOW_PORT), .WIN_RESET(8'h08)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .win_q(win_q), .boot_sel_q(boot_sel_q),
        .shadow_q(shadow_q)
    );

    mmd_region_decode #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) i_dec (
        .addr(mem_addr), .win(win_q), .boot_sel(boot_sel_q),
        .shadow(shadow_q), .tgt(tgt_dec), .page(ram_page), .off(rom_off)
    );

    // Output the decoded target code and the port readback.
    always_comb begin
        tgt      = tgt_dec;
        io_rdata = (io_addr == IO_AW'(WIN_PORT)) ? win_q : 8'hFF;
    end
endmodule

// File: rtl/mmd_checker.sv
// Cycle-level properties of the memory map decoder, bound into the top.
module mmd_checker #(
    parameter int          IO_AW       = 16,
    parameter int          PAGE_W      = 9,
    parameter int          OFF_W       = 17,
    parameter logic [15:0] WIN_PORT    = 16'h0461,
    parameter logic [15:0] BOOT_PORT   = 16'h043D,
    parameter logic [15:0] SHADOW_PORT = 16'h053D
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_wr,
    input logic [IO_AW-1:0]  io_addr,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic [31:0]       mem_addr,
    input logic [2:0]        tgt,
    input logic [PAGE_W-1:0] ram_page,
    input logic [OFF_W-1:0]  rom_off,
    input logic [7:0]        win_q,
    input logic              boot_sel_q,
    input logic              shadow_q
);
    p_reset_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (win_q == 8'h08 && boot_sel_q && !shadow_q));

    p_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == IO_AW'(WIN_PORT)) |-> (io_rdata == win_q));

    p_same_high_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == IO_AW'(WIN_PORT) && io_wdata[7:1] == win_q[7:1])
        |=> $stable(win_q));

    p_boot_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == IO_AW'(BOOT_PORT) &&
         (io_wdata == 8'h02 || io_wdata == 8'h12)) |=> !boot_sel_q);

    p_shadow_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == IO_AW'(SHADOW_PORT)) |=> (shadow_q == $past(io_wdata[1])));

    p_low_ram_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr < 32'h80000) |-> (tgt == 3'd0 && ram_page == PAGE_W'(mem_addr[19:15])));

    p_bios_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt == 3'd1) |-> (!boot_sel_q && !shadow_q && rom_off < OFF_W'(17'h18000)));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt == 3'd4) |-> (ram_page == '0 && rom_off == '0));
endmodule

bind memmap_decoder mmd_checker #(
    .IO_AW(IO_AW), .PAGE_W(PAGE_W), .OFF_W(OFF_W), .WIN_PORT(WIN_PORT),
    .BOOT_PORT(BOOT_PORT), .SHADOW_PORT(SHADOW_PORT)
) i_chk (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_addr(mem_addr),
    .tgt(tgt), .ram_page(ram_page), .rom_off(rom_off), .win_q(win_q),
    .boot_sel_q(boot_sel_q), .shadow_q(shadow_q)
);

// File: tb/test_memmap_decoder.sv
// Bench: directed corner cases plus seeded random port writes and addresses,
// checked against a reference decode kept in the bench.
module test_memmap_decoder;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic [31:0] mem_addr = 32'h0;
    logic [2:0]  tgt;
    logic [8:0]  ram_page;
    logic [16:0] rom_off;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_win = 8'h08;
    bit         m_boot = 1;
    bit         m_shadow = 0;

    always #(PERIOD/2) clk = ~clk;

    memmap_decoder i_memmap_decoder (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_addr(mem_addr),
        .tgt(tgt), .ram_page(ram_page), .rom_off(rom_off)
    );

    // Reference decode: returns {target, page, offset}.
    function automatic logic [28:0] ref_decode(input logic [31:0] a);
        logic [4:0]  p = a[19:15];
        logic [2:0]  t = 3'd4;
        logic [8:0]  pg = 9'd0;
        logic [16:0] of = 17'd0;
        if (a >= 32'h0010_0000 && a < 32'h0100_0000) begin
            t = 3'd0; pg = a[23:15];
        end else if (a < 32'h0010_0000 || a >= 32'hFFF0_0000) begin
            if (p < 5'd16) begin t = 3'd0; pg = {4'd0, p}; end
            else if (p < 5'd20) begin t = 3'd0; pg = {m_win[7:1], p[1:0]}; end
            else if (p >= 5'd24 && p <= 5'd27) begin
                if (m_shadow) begin t = 3'd0; pg = {4'd0, p}; end
                else if (p == 5'd27 && a[14:13] == 2'b00) begin
                    t = 3'd3; of = {4'd0, a[12:0]};
                end
            end else if (p >= 5'd29) begin
                if (m_boot) begin
                    if (p == 5'd31) begin t = 3'd2; of = {2'd0, a[14:0]}; end
                end else if (m_shadow) begin t = 3'd0; pg = {4'd0, p}; end
                else begin t = 3'd1; of = 17'(a[19:0] - 20'hE8000); end
            end
        end
        return {t, pg, of};
    endfunction

    // Requirement that governs an address under the current model state.
    function automatic string req_of(input logic [31:0] a);
        logic [4:0] p = a[19:15];
        if (a >= 32'hFFF0_0000) return "R9";
        if (a >= 32'h0100_0000) return "R10";
        if (a >= 32'h0010_0000) return "R1";
        if (p < 5'd16) return "R1";
        if (p < 5'd20) return "R2";
        if (p >= 5'd24 && p <= 5'd27) return "R8";
        if (p >= 5'd29) return m_boot ? "R6" : "R7";
        return "R10";
    endfunction

    task automatic check_addr(input logic [31:0] a, input string req);
        logic [28:0] e;
        @(negedge clk);
        mem_addr = a;
        #1;
        e = ref_decode(a);
        checks++;
        if ({tgt, ram_page, rom_off} !== e) begin
            errors++;
            $display("FAIL %s addr=%h actual tgt=%0d page=%0d off=%h expected tgt=%0d page=%0d off=%h",
                     req, a, tgt, ram_page, rom_off, e[28:26], e[25:17], e[16:0]);
        end
    endtask

    task automatic check_rd(input logic [15:0] port, input string req);
        logic [7:0] e;
        @(negedge clk);
        io_addr = port;
        #1;
        e = (port == 16'h0461) ? m_win : 8'hFF;
        checks++;
        if (io_rdata !== e) begin
            errors++;
            $display("FAIL %s port=%h actual=%h expected=%h", req, port, io_rdata, e);
        end
    endtask

    task automatic model_write(input logic [15:0] port, input logic [7:0] d);
        if (port == 16'h0461 && d[7:1] != m_win[7:1]) m_win = d;
        if (port == 16'h043D && (d == 8'h00 || d == 8'h10)) m_boot = 1;
        if (port == 16'h043D && (d == 8'h02 || d == 8'h12)) m_boot = 0;
        if (port == 16'h053D) m_shadow = d[1];
    endtask

    task automatic io_write(input logic [15:0] port, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = port; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
        model_write(port, d);
    endtask

    function automatic logic [31:0] rand_addr();
        logic [31:0] r = $urandom;
        case ($urandom_range(0, 5))
            0, 1, 2: return {12'h000, r[19:0]};
            3:       return {12'hFFF, r[19:0]};
            4:       return {8'h00, 4'h1 + 4'(r[23:20] % 15), r[19:0]};
            default: return (r < 32'h0100_0000) ? r + 32'h0100_0000 : r;
        endcase
    endfunction

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // Reset state (R3, R5, R6, R8, R10).
        check_rd(16'h0461, "R3");
        check_rd(16'h0534, "R3");
        check_addr(32'h000F_8123, "R6");
        check_addr(32'h000E_8000, "R6");
        check_addr(32'h000D_9FFF, "R8");
        check_addr(32'h000D_A000, "R8");
        check_addr(32'h000A_0000, "R10");
        check_addr(32'h000E_4000, "R10");
        check_addr(32'h0009_FFFF, "R2");
        check_addr(32'h0000_7FFF, "R1");
        check_addr(32'h00FF_FFFF, "R1");
        check_addr(32'h0100_0000, "R10");
        check_addr(32'hFFEF_FFFF, "R10");
        check_addr(32'hFFF8_8000, "R9");

        // Window register: bit-0-only change ignored, real change applied (R4, R2).
        io_write(16'h0461, 8'h09);
        check_rd(16'h0461, "R4");
        io_write(16'h0461, 8'h0B);
        check_rd(16'h0461, "R4");
        check_addr(32'h0008_8000, "R2");
        io_write(16'h0461, 8'hFF);
        check_addr(32'hFFF9_8001, "R9");

        // Boot ROM codes: ignored value, then deselect seen only after the edge (R5, R11, R7).
        io_write(16'h043D, 8'h01);
        check_addr(32'h000F_8000, "R5");
        @(negedge clk);
        io_wr = 1'b1; io_addr = 16'h043D; io_wdata = 8'h12;
        mem_addr = 32'h000F_8000;
        #1;
        checks++;
        if (tgt !== 3'd2) begin
            errors++;
            $display("FAIL R11 before edge actual tgt=%0d expected tgt=2", tgt);
        end
        @(negedge clk);
        io_wr = 1'b0;
        model_write(16'h043D, 8'h12);
        check_addr(32'h000F_8000, "R11");
        check_addr(32'h000E_8000, "R7");
        check_addr(32'h000F_FFFF, "R7");

        // Shadow on/off with boot ROM deselected and selected (R8, R7, R6).
        io_write(16'h053D, 8'h02);
        check_addr(32'h000C_0000, "R8");
        check_addr(32'h000F_0000, "R7");
        io_write(16'h043D, 8'h10);
        check_addr(32'h000E_8000, "R6");
        check_addr(32'h000F_8004, "R6");
        io_write(16'h053D, 8'hFD);
        check_addr(32'h000D_8010, "R8");
        io_write(16'h043D, 8'h02);
        io_write(16'h043D, 8'h00);
        check_addr(32'h000F_A000, "R5");

        // Random port writes mixed with random addresses.
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 1) == 1) begin
                logic [15:0] port;
                logic [7:0]  d = 8'($urandom);
                case ($urandom_range(0, 3))
                    0: begin
                        port = 16'h0461;
                        if ($urandom_range(0, 2) == 0) d = m_win ^ 8'h01;
                    end
                    1: begin
                        port = 16'h043D;
                        case ($urandom_range(0, 4))
                            0: d = 8'h00;
                            1: d = 8'h10;
                            2: d = 8'h02;
                            3: d = 8'h12;
                            default: ;
                        endcase
                    end
                    2: port = 16'h053D;
                    default: port = 16'h0400 + 16'($urandom_range(0, 255));
                endcase
                io_write(port, d);
                check_rd(16'h0461, "R4");
            end
            for (int k = 0; k < 4; k++) begin
                logic [31:0] a = rand_addr();
                check_addr(a, req_of(a));
            end
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule